// File: doc/BRIEF.md
# Streaming Reed-Solomon Encoder

This block turns a stream of message symbols, one per clock, into a systematic Reed-Solomon codeword over GF(2^M). Each input symbol comes with valid, start and end strobes. The message symbols are forwarded unchanged, one register stage late. Right after the last message symbol the block appends the N−K parity symbols, one per cycle. The output carries its own valid, start and end strobes.

The parity is the remainder of m(x)·x^(N−K) divided by the generator polynomial g(x). That polynomial has the N−K consecutive roots alpha^B … alpha^(B+N−K−1), where alpha is a root of the chosen primitive polynomial. The remainder is computed by a linear-feedback shift register with constant GF multipliers.

A ready output (`next_frame`) shows when a fresh frame may begin. Shortened frames are allowed. An optional elaboration-time mask can thin the parity stream.

The symbol width, codeword length, message length, primitive polynomial, first root power, puncture enable and puncture mask are all parameters. The defaults are M=3, N=7, K=3, primitive polynomial x^3+x+1 (value 11), and B=1.

Top module: `rs_enc_top`

## Requirements
- R1: A full frame of K valid message symbols produces N output symbols. The first K equal the input symbols in order. The next N−K are the remainder of m(x)·x^(N−K) mod g(x), highest degree first. The first symbol of a frame is the highest-degree coefficient. Every emitted codeword evaluates to zero at each generator root.
- R2: A symbol sampled at a clock edge appears on `out_data` with `out_valid` high after the next edge, so latency is one cycle. The parity symbols follow the last message symbol on consecutive cycles.
- R3: `out_start` is high only on the first message symbol of a frame. `out_end` is high only on the last emitted parity symbol. The two are never high together, and `out_end` implies `out_valid`.
- R4: `next_frame` is high while idle. It goes low in the cycle after an accepted start and stays low for the whole message and the N−K parity cycles. It returns high in the cycle right after the last parity slot, so a new start may follow the last message symbol after a gap of exactly N−K cycles.
- R5: `in_start`, `in_end` and `in_data` have no effect in a cycle where `in_valid` is low.
- R6: A valid start, in any phase including the message or parity phase of an earlier frame, drops that frame and begins a new codeword with the current symbol.
- R7: After the message has closed, further end strobes and valid symbols without start are ignored until the next valid start.
- R8: A valid end before K symbols closes a shortened message of L symbols. L message symbols are then followed by N−K parity symbols computed as if K−L leading zero symbols had been sent.
- R9: The K-th valid message symbol closes the message even if `in_end` is low.
- R10: While idle, valid symbols without a start produce no output and leave `next_frame` high.
- R11: With puncturing on, bit j of the (N−K)-bit mask governs the j-th parity symbol emitted, with bit 0 being the first. A 1 emits that symbol; a 0 keeps its cycle but holds `out_valid` low. `out_end` marks the last emitted parity symbol. The default mask is 4'b0011: the first two parity symbols are emitted, the last two are dropped.
- R12: A synchronous active-high reset clears `out_valid`, `out_start` and `out_end`, sets `next_frame` high, and abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | SYM_W | Message symbol |
| in_valid | input | 1 | Input symbol and strobes are meaningful |
| in_start | input | 1 | First symbol of a frame |
| in_end | input | 1 | Last message symbol of a frame |
| out_data | output | SYM_W | Codeword symbol (zero when not valid) |
| out_valid | output | 1 | Output symbol is meaningful |
| out_start | output | 1 | First codeword symbol |
| out_end | output | 1 | Last emitted parity symbol |
| next_frame | output | 1 | A new frame may start |

## Verification
The properties assume that `in_data` is defined whenever `in_valid` and `in_start` are both high. They also assume that reset is held for at least one clock before the first frame. Without that, the one-cycle echo of a start symbol and the fall of the ready flag have no well-defined past to refer to. The stimulus drives every input to a known value from time zero and only changes inputs shortly after a rising edge. It keeps reset high for several cycles at power-up and during the mid-frame reset scenario. A second instance with puncturing on shares the same stimulus, so every frame pattern also exercises the masked parity path.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MSG,
        PH_PAR
    } phase_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_SEED,
        OP_FEED,
        OP_DRAIN
    } lfsr_op_e;

    typedef struct packed {
        logic vld;
        logic sof;
        logic eof;
        logic from_par;
    } beat_ctl_t;

    // Multiply two GF(2^m) elements, reducing by poly (poly includes x^m).
    function automatic int unsigned gf_mul(int unsigned a, int unsigned b,
                                           int m, int unsigned poly);
        int unsigned acc = 0;
        int unsigned x   = a;
        for (int i = 0; i < 16; i++) begin
            if (i < m) begin
                if (((b >> i) & 1) != 0) acc = acc ^ x;
                x = x << 1;
                if (((x >> m) & 1) != 0) x = x ^ poly;
            end
        end
        return acc;
    endfunction

    // alpha^e in GF(2^m), alpha being the root of poly.
    function automatic int unsigned gf_alpha_pow(int e, int m, int unsigned poly);
        int unsigned r   = 1;
        int          ord = (1 << m) - 1;
        int          k   = e % ord;
        for (int i = 0; i < k; i++) begin
            r = r << 1;
            if (((r >> m) & 1) != 0) r = r ^ poly;
        end
        return r;
    endfunction

endpackage

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
    import rs_enc_pkg::*;
#(
    parameter int          SYM_W      = 3,
    parameter int          NPAR       = 4,
    parameter int unsigned POLY       = 11,
    parameter int          FIRST_ROOT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  lfsr_op_e         op,
    input  logic [SYM_W-1:0] din,
    output logic [SYM_W-1:0] par_top
);

    typedef logic [NPAR:0][SYM_W-1:0] gen_t;

    // Generator polynomial coefficients, index = degree, g[NPAR] = 1.
    function automatic gen_t build_gen();
        gen_t        g = '0;
        int unsigned t;
        g[0] = SYM_W'(1);
        for (int i = 0; i < NPAR; i++) begin
            int unsigned root;
            root = gf_alpha_pow(FIRST_ROOT + i, SYM_W, POLY);
            for (int j = NPAR; j >= 1; j--) begin
                t    = gf_mul(32'(g[j]), root, SYM_W, POLY);
                g[j] = g[j-1] ^ t[SYM_W-1:0];
            end
            t    = gf_mul(32'(g[0]), root, SYM_W, POLY);
            g[0] = t[SYM_W-1:0];
        end
        return g;
    endfunction

    localparam gen_t GEN = build_gen();

    logic [SYM_W-1:0] par_q [NPAR];
    logic [SYM_W-1:0] par_d [NPAR];
    logic [SYM_W-1:0] fb;

    always_comb begin
        unique case (op)
            OP_SEED: fb = din;
            OP_FEED: fb = din ^ par_q[NPAR-1];
            default: fb = '0;
        endcase
    end

    for (genvar i = 0; i < NPAR; i++) begin : g_tap
        int unsigned      mul_full;
        logic [SYM_W-1:0] tap;
        logic [SYM_W-1:0] prev;

        always_comb mul_full = gf_mul(32'(fb), 32'(GEN[i]), SYM_W, POLY);
        assign tap = mul_full[SYM_W-1:0];

        if (i == 0) begin : g_low
            assign prev = '0;
        end else begin : g_up
            assign prev = (op == OP_SEED) ? '0 : par_q[i-1];
        end

        assign par_d[i] = prev ^ tap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
        end else if (op != OP_HOLD) begin
            for (int i = 0; i < NPAR; i++) par_q[i] <= par_d[i];
        end
    end

    assign par_top = par_q[NPAR-1];

endmodule

// File: rtl/rs_frame_ctrl.sv
module rs_frame_ctrl
    import rs_enc_pkg::*;
#(
    parameter int              K_LEN      = 3,
    parameter int              NPAR       = 4,
    parameter bit              PUNCT_ON   = 1'b0,
    parameter logic [NPAR-1:0] PUNCT_MASK = '1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_vld,
    input  logic      in_sof,
    input  logic      in_eof,
    output lfsr_op_e  op,
    output beat_ctl_t ctl,
    output logic      ready
);

    localparam int MCW = $clog2(K_LEN + 1);
    localparam int PCW = $clog2(NPAR + 1);
    localparam logic [NPAR-1:0] KEEP = PUNCT_ON ? PUNCT_MASK : {NPAR{1'b1}};

    function automatic int last_kept(logic [NPAR-1:0] m);
        int r = 0;
        for (int i = 0; i < NPAR; i++) if (m[i]) r = i;
        return r;
    endfunction

    localparam int LAST_KEPT = last_kept(KEEP);

    phase_e           phase_q, phase_d;
    logic [MCW-1:0]   mcnt_q, mcnt_d;
    logic [PCW-1:0]   pcnt_q, pcnt_d;
    logic             take_sof;

    assign take_sof = in_vld & in_sof;

    always_comb begin
        phase_d = phase_q;
        mcnt_d  = mcnt_q;
        pcnt_d  = pcnt_q;
        op      = OP_HOLD;
        ctl     = '0;
        if (take_sof) begin
            op      = OP_SEED;
            ctl.vld = 1'b1;
            ctl.sof = 1'b1;
            mcnt_d  = MCW'(1);
            pcnt_d  = '0;
            phase_d = in_eof ? PH_PAR : PH_MSG;
        end else begin
            unique case (phase_q)
                PH_MSG: begin
                    if (in_vld) begin
                        op      = OP_FEED;
                        ctl.vld = 1'b1;
                        mcnt_d  = mcnt_q + 1'b1;
                        if (in_eof || mcnt_q == MCW'(K_LEN - 1)) begin
                            phase_d = PH_PAR;
                            pcnt_d  = '0;
                        end
                    end
                end
                PH_PAR: begin
                    op           = OP_DRAIN;
                    ctl.from_par = 1'b1;
                    ctl.vld      = KEEP[pcnt_q];
                    ctl.eof      = (pcnt_q == PCW'(LAST_KEPT));
                    pcnt_d       = pcnt_q + 1'b1;
                    if (pcnt_q == PCW'(NPAR - 1)) phase_d = PH_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            mcnt_q  <= '0;
            pcnt_q  <= '0;
        end else begin
            phase_q <= phase_d;
            mcnt_q  <= mcnt_d;
            pcnt_q  <= pcnt_d;
        end
    end

    assign ready = (phase_q == PH_IDLE);

endmodule

// File: rtl/rs_enc_top.sv
module rs_enc_top
    import rs_enc_pkg::*;
#(
    parameter int          SYM_W      = 3,
    parameter int          CW_LEN     = 7,
    parameter int          MSG_LEN    = 3,
    parameter int unsigned PRIM_POLY  = 11,
    parameter int          FIRST_ROOT = 1,
    parameter bit          PUNCT_ON   = 1'b0,
    parameter logic [CW_LEN-MSG_LEN-1:0] PUNCT_MASK = 'b0011
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] in_data,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic             in_end,
    output logic [SYM_W-1:0] out_data,
    output logic             out_valid,
    output logic             out_start,
    output logic             out_end,
    output logic             next_frame
);

    localparam int NPAR = CW_LEN - MSG_LEN;

    if (CW_LEN != (1 << SYM_W) - 1) begin : g_bad_len
        $error("codeword length must be 2^SYM_W - 1");
    end
    if (MSG_LEN < 3 || MSG_LEN > CW_LEN - 2) begin : g_bad_msg
        $error("message length out of range");
    end

    lfsr_op_e         op;
    beat_ctl_t        ctl;
    beat_ctl_t        ctl_q;
    logic [SYM_W-1:0] par_top;
    logic [SYM_W-1:0] data_q;

    rs_frame_ctrl #(
        .K_LEN      (MSG_LEN),
        .NPAR       (NPAR),
        .PUNCT_ON   (PUNCT_ON),
        .PUNCT_MASK (PUNCT_MASK)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .in_vld (in_valid),
        .in_sof (in_start),
        .in_eof (in_end),
        .op     (op),
        .ctl    (ctl),
        .ready  (next_frame)
    );

    rs_parity_lfsr #(
        .SYM_W      (SYM_W),
        .NPAR       (NPAR),
        .POLY       (PRIM_POLY),
        .FIRST_ROOT (FIRST_ROOT)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .din     (in_data),
        .par_top (par_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            data_q <= '0;
        end else begin
            ctl_q  <= ctl;
            if (!ctl.vld)         data_q <= '0;
            else if (ctl.from_par) data_q <= par_top;
            else                   data_q <= in_data;
        end
    end

    assign out_data  = data_q;
    assign out_valid = ctl_q.vld;
    assign out_start = ctl_q.sof;
    assign out_end   = ctl_q.eof;

endmodule

// File: rtl/rs_enc_chk.sv
module rs_enc_chk #(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] in_data,
    input logic         in_valid,
    input logic         in_start,
    input logic [W-1:0] out_data,
    input logic         out_valid,
    input logic         out_start,
    input logic         out_end,
    input logic         next_frame
);

    // R2
    start_echo_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start) |=> (out_valid && out_start && out_data == $past(in_data)));

    // R3
    sof_eof_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_start && out_end));

    // R3
    eof_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_end |-> out_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (next_frame && !(in_valid && in_start)) |=> !out_valid);

    // R4
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(next_frame) |-> $past(in_valid && in_start));

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_start && !out_end && next_frame));

endmodule

bind rs_enc_top rs_enc_chk #(.W(SYM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_start   (in_start),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_start  (out_start),
    .out_end    (out_end),
    .next_frame (next_frame)
);

// File: tb/tb_rs_enc_top.sv
module tb_rs_enc_top;

    localparam int W = 3, N = 7, K = 3, P = 4, POLY = 11, B = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] in_data = '0;
    logic in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [W-1:0] out_data, p_data;
    logic out_valid, out_start, out_end, next_frame;
    logic p_valid, p_start, p_end, p_next;

    always #10 clk = ~clk;

    rs_enc_top dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_start(in_start), .in_end(in_end), .out_data(out_data),
        .out_valid(out_valid), .out_start(out_start), .out_end(out_end),
        .next_frame(next_frame)
    );

    rs_enc_top #(.PUNCT_ON(1'b1), .PUNCT_MASK(4'b0011)) dut_p (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_start(in_start), .in_end(in_end), .out_data(p_data),
        .out_valid(p_valid), .out_start(p_start), .out_end(p_end),
        .next_frame(p_next)
    );

    int checks = 0, fails = 0, cyc = 0;
    int exp_t [N];
    int log_t [N+1];
    int gpoly [P+1];
    int msg [8];
    int exp_cw [16];
    int cap_d [64], cap_s [64], cap_e [64], cap_c [64];
    int pcap_d [64], pcap_s [64], pcap_e [64];
    int cap_n = 0, pcap_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid && cap_n < 64) begin
            cap_d[cap_n] = int'(out_data); cap_s[cap_n] = int'(out_start);
            cap_e[cap_n] = int'(out_end);  cap_c[cap_n] = cyc;
            cap_n++;
        end
        if (!rst && p_valid && pcap_n < 64) begin
            pcap_d[pcap_n] = int'(p_data); pcap_s[pcap_n] = int'(p_start);
            pcap_e[pcap_n] = int'(p_end);
            pcap_n++;
        end
    end

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int gm(int a, int b);
        if (a == 0 || b == 0) return 0;
        return exp_t[(log_t[a] + log_t[b]) % N];
    endfunction

    task automatic build_field();
        int x = 1;
        int tmp [P+1];
        for (int i = 0; i < N; i++) begin
            exp_t[i] = x; log_t[x] = i;
            x = x << 1;
            if ((x & (1 << W)) != 0) x = x ^ POLY;
        end
        for (int j = 0; j <= P; j++) gpoly[j] = 0;
        gpoly[0] = 1;
        for (int i = 0; i < P; i++) begin
            int root = exp_t[(B + i) % N];
            for (int j = 0; j <= P; j++)
                tmp[j] = gm(gpoly[j], root) ^ ((j > 0) ? gpoly[j-1] : 0);
            for (int j = 0; j <= P; j++) gpoly[j] = tmp[j];
        end
    endtask

    // Long division of m(x)*x^P by g(x); parity highest degree first.
    task automatic compute_expected(int len);
        int dv [16];
        for (int i = 0; i < 16; i++) dv[i] = 0;
        for (int i = 0; i < len; i++) dv[i] = msg[i];
        for (int i = 0; i < len; i++) begin
            int c = dv[i];
            if (c != 0)
                for (int j = 0; j <= P; j++) dv[i+j] = dv[i+j] ^ gm(c, gpoly[P-j]);
        end
        for (int i = 0; i < len; i++) exp_cw[i] = msg[i];
        for (int i = 0; i < P; i++) exp_cw[len+i] = dv[len+i];
    endtask

    task automatic check_cw(string tag, int base, int len);
        int total = len + P;
        int ends = 0;
        compute_expected(len);
        for (int i = 0; i < total; i++) begin
            chk(cap_d[base+i] == exp_cw[i], {tag, " R1 symbol"}, cap_d[base+i], exp_cw[i]);
            ends += cap_e[base+i];
        end
        chk(cap_s[base] == 1, {tag, " R3 start flag"}, cap_s[base], 1);
        chk(cap_e[base+total-1] == 1 && ends == 1, {tag, " R3 end flag"}, ends, 1);
        for (int r = 0; r < P; r++) begin
            int root = exp_t[(B + r) % N];
            int v = 0;
            for (int i = 0; i < total; i++) v = gm(v, root) ^ cap_d[base+i];
            chk(v == 0, {tag, " R1 root value"}, v, 0);
        end
    endtask

    task automatic drive(bit v, bit s, bit e, int d);
        @(posedge clk); #2;
        in_valid = v; in_start = s; in_end = e; in_data = W'(d);
    endtask

    task automatic idle(int n);
        repeat (n) drive(0, 0, 0, 0);
    endtask

    task automatic clear_cap();
        cap_n = 0; pcap_n = 0;
    endtask

    task automatic t_reset();
        chk(out_valid == 0 && out_start == 0 && out_end == 0, "R12 outputs in reset", int'(out_valid), 0);
        chk(next_frame == 1 && p_next == 1, "R12 ready in reset", int'(next_frame), 1);
    endtask

    task automatic t_full();
        int c0;
        clear_cap();
        msg[0] = 5; msg[1] = 2; msg[2] = 7;
        drive(1, 1, 0, 5); c0 = cyc;
        drive(1, 0, 0, 2);
        drive(1, 0, 1, 7);
        idle(P + 3);
        chk(cap_n == 7, "R1 full frame beat count", cap_n, 7);
        check_cw("full", 0, 3);
        chk(cap_c[0] == c0 + 1, "R2 latency", cap_c[0] - c0, 1);
        chk(cap_c[6] == cap_c[0] + 6, "R2 parity contiguous", cap_c[6] - cap_c[0], 6);
    endtask

    task automatic t_zero();
        clear_cap();
        msg[0] = 0; msg[1] = 0; msg[2] = 0;
        drive(1, 1, 0, 0); drive(1, 0, 0, 0); drive(1, 0, 1, 0);
        idle(P + 3);
        chk(cap_n == 7, "R1 zero frame beat count", cap_n, 7);
        check_cw("zero", 0, 3);
    endtask

    task automatic t_b2b();
        clear_cap();
        drive(1, 1, 0, 5); drive(1, 0, 0, 2); drive(1, 0, 1, 7);
        for (int k = 1; k <= P; k++) begin
            drive(0, 0, 0, 0);
            chk(next_frame == 0, "R4 busy during parity", int'(next_frame), 0);
        end
        drive(1, 1, 0, 1);
        chk(next_frame == 1, "R4 ready after gap", int'(next_frame), 1);
        drive(1, 0, 0, 6); drive(1, 0, 1, 3);
        idle(P + 3);
        chk(cap_n == 14, "R4 back-to-back beat count", cap_n, 14);
        msg[0] = 5; msg[1] = 2; msg[2] = 7;
        check_cw("b2b first", 0, 3);
        msg[0] = 1; msg[1] = 6; msg[2] = 3;
        check_cw("b2b second", 7, 3);
        chk(cap_c[7] == cap_c[6] + 1, "R4 no idle between codewords", cap_c[7] - cap_c[6], 1);
    endtask

    task automatic t_short();
        clear_cap();
        msg[0] = 4; msg[1] = 3;
        drive(1, 1, 0, 4); drive(1, 0, 1, 3);
        idle(P + 3);
        chk(cap_n == 6, "R8 shortened beat count", cap_n, 6);
        check_cw("R8 short", 0, 2);
    endtask

    task automatic t_kclose();
        clear_cap();
        msg[0] = 3; msg[1] = 3; msg[2] = 1;
        drive(1, 1, 0, 3); drive(1, 0, 0, 3); drive(1, 0, 0, 1);
        drive(1, 0, 1, 6); drive(1, 0, 0, 2);
        idle(P + 3);
        chk(cap_n == 7, "R9 closes at K, R7 extras ignored", cap_n, 7);
        check_cw("R9 kclose", 0, 3);
    endtask

    task automatic t_multi_end();
        clear_cap();
        msg[0] = 2; msg[1] = 5;
        drive(1, 1, 0, 2); drive(1, 0, 1, 5); drive(1, 0, 1, 4);
        idle(P + 3);
        chk(cap_n == 6, "R7 first end wins", cap_n, 6);
        check_cw("R7 multi end", 0, 2);
    endtask

    task automatic t_restart();
        int starts = 0;
        clear_cap();
        drive(1, 1, 0, 6); drive(1, 0, 0, 1);
        drive(1, 1, 0, 2); drive(1, 0, 0, 4); drive(1, 0, 1, 5);
        idle(P + 3);
        chk(cap_n == 9, "R6 restart in message beat count", cap_n, 9);
        msg[0] = 2; msg[1] = 4; msg[2] = 5;
        check_cw("R6 restart msg", 2, 3);
        for (int i = 0; i < cap_n; i++) starts += cap_s[i];
        chk(starts == 2, "R6 two start flags", starts, 2);
        clear_cap();
        drive(1, 1, 0, 1); drive(1, 0, 0, 2); drive(1, 0, 1, 3);
        idle(1);
        drive(1, 1, 0, 7); drive(1, 0, 0, 7); drive(1, 0, 1, 7);
        idle(P + 3);
        chk(cap_n == 11, "R6 restart in parity beat count", cap_n, 11);
        msg[0] = 7; msg[1] = 7; msg[2] = 7;
        check_cw("R6 restart par", 4, 3);
    endtask

    task automatic t_bubbles();
        clear_cap();
        msg[0] = 3; msg[1] = 4; msg[2] = 2;
        drive(1, 1, 0, 3); drive(0, 1, 1, 6); drive(1, 0, 0, 4);
        drive(0, 0, 1, 1); drive(1, 0, 1, 2);
        idle(P + 3);
        chk(cap_n == 7, "R5 invalid strobes ignored", cap_n, 7);
        check_cw("R5 bubbles", 0, 3);
    endtask

    task automatic t_idle_junk();
        clear_cap();
        drive(1, 0, 0, 5); drive(1, 0, 1, 5); drive(1, 0, 0, 2);
        idle(3);
        chk(cap_n == 0, "R10 no output from junk", cap_n, 0);
        chk(next_frame == 1, "R10 ready kept", int'(next_frame), 1);
    endtask

    task automatic t_punct();
        clear_cap();
        msg[0] = 5; msg[1] = 2; msg[2] = 7;
        drive(1, 1, 0, 5); drive(1, 0, 0, 2); drive(1, 0, 1, 7);
        for (int k = 1; k <= P; k++) drive(0, 0, 0, 0);
        chk(p_next == 0, "R11 punctured slot still busy", int'(p_next), 0);
        drive(0, 0, 0, 0);
        chk(p_next == 1, "R11 ready after all slots", int'(p_next), 1);
        idle(3);
        compute_expected(3);
        chk(pcap_n == 5, "R11 punctured beat count", pcap_n, 5);
        for (int i = 0; i < 5; i++)
            chk(pcap_d[i] == exp_cw[i], "R11 kept symbol", pcap_d[i], exp_cw[i]);
        chk(pcap_s[0] == 1, "R11 start flag", pcap_s[0], 1);
        chk(pcap_e[4] == 1 && pcap_e[3] == 0, "R11 end on last kept", pcap_e[4], 1);
    endtask

    task automatic t_reset_mid();
        int n0;
        clear_cap();
        drive(1, 1, 0, 5); drive(1, 0, 1, 2);
        @(posedge clk); #2; rst = 1'b1; in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
        @(posedge clk); #2;
        chk(out_valid == 0 && out_end == 0, "R12 outputs cleared", int'(out_valid), 0);
        chk(next_frame == 1, "R12 ready after reset", int'(next_frame), 1);
        rst = 1'b0;
        n0 = cap_n;
        idle(P + 2);
        chk(cap_n == n0, "R12 frame abandoned", cap_n, n0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        build_field();
        repeat (5) @(posedge clk);
        #2;
        t_reset();
        rst = 1'b0;
        idle(2);
        t_full();
        t_zero();
        t_b2b();
        t_short();
        t_kclose();
        t_multi_end();
        t_restart();
        t_bubbles();
        t_idle_junk();
        t_punct();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule